// File: doc/BRIEF.md
# Interrupt Gating and Conditional Return Unit

This unit sits beside a small CPU core. It collects one event flag per peripheral module into an identification register and gates that register with a per-module enable mask and a single in-service bit. When a request is pending and the core reaches an instruction boundary, the unit drives a program-counter load to one fixed vector address. In the same cycle it pushes the interrupted program counter onto a hardware return stack and sets the in-service bit. While that bit is set, every source is held off. A handler can clear the bit through its write port to allow nesting. It can save and restore the mask through the software push/pop port of the same stack.

Return instructions arrive as a decode strobe with a 3-bit condition code. The code is evaluated against the carry, zero and sign status flags. A return whose condition holds pops the stack, reloads the program counter with the popped address and clears the in-service bit. A return whose condition fails changes nothing. Masking a module only suppresses its request. The module's identification bit still sets, so software can test flag and mask together.

Top module: `irq_gate_ret`

## Requirements
- R1: A high `mod_set[i]` sets identification bit `irq_id[i]` at the next clock edge whatever the mask holds, and the bit stays readable.
- R2: An identification bit clears only when its `mod_clr[i]` is high; if set and clear are both high in one cycle, the bit ends up set.
- R3: `irq_req` is high exactly when `in_service` is 0 and `irq_id & irq_mask` is nonzero; a mask bit of 0 removes that module from the request.
- R4: When `irq_req` and `fetch_boundary` are high and `ret_valid` is low, `pc_load` is high in that cycle with `pc_load_addr` equal to `VEC_ADDR`, `cur_pc` is pushed, and `in_service` reads 1 after the edge.
- R5: While `in_service` is 1 no request is raised; `mask_we` loads `irq_mask` at the next edge, and `insv_we` loads `in_service` only in a cycle with neither a vector entry nor a return strobe.
- R6: `ret_cond` encodes 0 always, 1 carry set, 2 carry clear, 3 zero set, 4 zero clear, 5 sign set; codes 6 and 7 are never true.
- R7: A return strobe whose condition is true and whose stack is non-empty drives `pc_load` with `pc_load_addr` equal to the top entry, pops it, and clears `in_service` at the edge.
- R8: A return strobe whose condition is false leaves `in_service`, the stack depth and the top entry unchanged and drives no `pc_load`.
- R9: The stack holds `STK_DEPTH` (default 8) entries; a push when full or a pop when empty leaves the depth unchanged and sets `stk_err`, which stays set until reset. A true return on an empty stack also drives no load and leaves `in_service` unchanged.
- R10: `sw_push` stores `sw_push_data` and `sw_pop` removes the top, which `stk_top` shows beforehand. Push wins over pop. Both are dropped in a cycle with a vector entry or a return strobe.
- R11: After reset, `irq_id`, `irq_mask`, `in_service`, `stk_depth` and `stk_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_set | input | N_SRC | Per-module event set strobes |
| mod_clr | input | N_SRC | Per-module identification clear strobes |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | N_SRC | Mask write value |
| insv_we | input | 1 | In-service bit write enable |
| insv_wdata | input | 1 | In-service write value |
| ret_valid | input | 1 | Return instruction decoded this cycle |
| ret_cond | input | 3 | Return condition code |
| flag_c | input | 1 | Carry status flag |
| flag_z | input | 1 | Zero status flag |
| flag_s | input | 1 | Sign status flag |
| fetch_boundary | input | 1 | Core is at an instruction boundary |
| cur_pc | input | PC_W | Return address to save on vector entry |
| sw_push | input | 1 | Software stack push |
| sw_pop | input | 1 | Software stack pop |
| sw_push_data | input | PC_W | Software push value |
| pc_load | output | 1 | Program counter load strobe |
| pc_load_addr | output | PC_W | Program counter load value |
| irq_id | output | N_SRC | Identification register |
| irq_mask | output | N_SRC | Mask register |
| in_service | output | 1 | In-service bit |
| irq_req | output | 1 | Gated interrupt request |
| stk_top | output | PC_W | Top stack entry, 0 when empty |
| stk_depth | output | clog2(STK_DEPTH+1) | Entries on the stack |
| stk_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The block's state is small and it is all visible: identification bits, mask, in-service bit, stack depth, stack top and error flag. So a corrupted register shows at the ports one clock after the faulty edge, and the bench compares every one of them each cycle. A wrong stack entry stays hidden until it reaches the top. It then shows either as a wrong `pc_load_addr` on a true return or as a wrong `stk_top` ahead of a software pop. A condition-decode fault shows in the same cycle as a missing or extra `pc_load` against the flags, and as a wrong depth after the edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam logic [2:0] COND_ALWAYS = 3'd0;
    localparam logic [2:0] COND_C      = 3'd1;
    localparam logic [2:0] COND_NC     = 3'd2;
    localparam logic [2:0] COND_Z      = 3'd3;
    localparam logic [2:0] COND_NZ     = 3'd4;
    localparam logic [2:0] COND_S      = 3'd5;

    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // Return condition decode; reserved codes never hold (R6)
    function automatic logic cond_met(input logic [2:0] code,
                                      input logic c, input logic z,
                                      input logic s);
        case (code)
            COND_ALWAYS: return 1'b1;
            COND_C:      return c;
            COND_NC:     return !c;
            COND_Z:      return z;
            COND_NZ:     return !z;
            COND_S:      return s;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_ident.sv
module irq_ident #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    input  logic             insv_i,
    output logic [N_SRC-1:0] id_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             req_o
);

    typedef struct packed {
        logic [N_SRC-1:0] id;
        logic [N_SRC-1:0] mask;
    } ident_st_t;

    ident_st_t st_d, st_q;
    logic [N_SRC-1:0] gated;

    always_comb begin
        st_d = st_q;
        // set dominates clear on the same bit
        for (int i = 0; i < N_SRC; i++) begin
            if (set_i[i])      st_d.id[i] = 1'b1;
            else if (clr_i[i]) st_d.id[i] = 1'b0;
        end
        if (mask_we_i) st_d.mask = mask_wdata_i;
        gated = st_q.id & st_q.mask;
        req_o = !insv_i && (gated != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_o   = st_q.id;
    assign mask_o = st_q.mask;

    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((id_o & $past(set_i)) == $past(set_i)));

    assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(id_o) & ~$past(clr_i)) & ~id_o) == '0));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));

endmodule

// File: rtl/irq_retstack.sv
module irq_retstack
    import irq_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  stk_op_e                      op_i,
    input  logic [W-1:0]                 wdata_i,
    output logic [W-1:0]                 top_o,
    output logic [$clog2(DEPTH+1)-1:0]   depth_o,
    output logic                         err_o
);

    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           sp;
        logic                    err;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [PW-1:0] sp_m1;

    always_comb begin
        st_d  = st_q;
        sp_m1 = st_q.sp - PW'(1);
        case (op_i)
            STK_PUSH: begin
                if (st_q.sp == FULL) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.mem[st_q.sp[AW-1:0]] = wdata_i;
                    st_d.sp = st_q.sp + PW'(1);
                end
            end
            STK_POP: begin
                if (st_q.sp == '0) st_d.err = 1'b1;
                else               st_d.sp  = sp_m1;
            end
            default: ;
        endcase
        top_o = (st_q.sp == '0) ? '0 : st_q.mem[sp_m1[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth_o = st_q.sp;
    assign err_o   = st_q.err;

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= FULL);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_full_push_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH && depth_o == FULL) |=> ($stable(depth_o) && err_o));

    assert_empty_pop_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_POP && depth_o == '0) |=> ($stable(depth_o) && err_o));

endmodule

// File: rtl/irq_gate_ret.sv
module irq_gate_ret
    import irq_pkg::*;
#(
    parameter int              N_SRC     = 8,
    parameter int              PC_W      = 16,
    parameter int              STK_DEPTH = 8,
    parameter logic [PC_W-1:0] VEC_ADDR  = 16'h0040
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SRC-1:0]                  mod_set,
    input  logic [N_SRC-1:0]                  mod_clr,
    input  logic                              mask_we,
    input  logic [N_SRC-1:0]                  mask_wdata,
    input  logic                              insv_we,
    input  logic                              insv_wdata,
    input  logic                              ret_valid,
    input  logic [2:0]                        ret_cond,
    input  logic                              flag_c,
    input  logic                              flag_z,
    input  logic                              flag_s,
    input  logic                              fetch_boundary,
    input  logic [PC_W-1:0]                   cur_pc,
    input  logic                              sw_push,
    input  logic                              sw_pop,
    input  logic [PC_W-1:0]                   sw_push_data,
    output logic                              pc_load,
    output logic [PC_W-1:0]                   pc_load_addr,
    output logic [N_SRC-1:0]                  irq_id,
    output logic [N_SRC-1:0]                  irq_mask,
    output logic                              in_service,
    output logic                              irq_req,
    output logic [PC_W-1:0]                   stk_top,
    output logic [$clog2(STK_DEPTH+1)-1:0]    stk_depth,
    output logic                              stk_err
);

    typedef struct packed {
        logic insv;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic            cond_ok;
    logic            take;
    logic            ret_go;
    logic            ret_exec;
    stk_op_e         stk_op;
    logic [PC_W-1:0] stk_wdata;

    irq_ident #(.N_SRC(N_SRC)) u_ident (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (mod_set),
        .clr_i        (mod_clr),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .insv_i       (st_q.insv),
        .id_o         (irq_id),
        .mask_o       (irq_mask),
        .req_o        (irq_req)
    );

    irq_retstack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (stk_op),
        .wdata_i (stk_wdata),
        .top_o   (stk_top),
        .depth_o (stk_depth),
        .err_o   (stk_err)
    );

    always_comb begin
        st_d      = st_q;
        cond_ok   = cond_met(ret_cond, flag_c, flag_z, flag_s);
        ret_go    = ret_valid && cond_ok;
        ret_exec  = ret_go && (stk_depth != '0);
        take      = irq_req && fetch_boundary && !ret_valid;
        stk_op    = STK_NONE;
        stk_wdata = sw_push_data;

        if (take) begin
            stk_op    = STK_PUSH;
            stk_wdata = cur_pc;
        end else if (ret_go) begin
            stk_op = STK_POP;
        end else if (!ret_valid) begin
            if (sw_push)     stk_op = STK_PUSH;
            else if (sw_pop) stk_op = STK_POP;
        end

        if (take)                     st_d.insv = 1'b1;
        else if (ret_exec)            st_d.insv = 1'b0;
        else if (!ret_valid && insv_we) st_d.insv = insv_wdata;

        pc_load      = take || ret_exec;
        pc_load_addr = take ? VEC_ADDR : stk_top;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_service = st_q.insv;

    assert_vector_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && fetch_boundary && !ret_valid) |=> in_service);

    assert_blocked_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !irq_req);

    assert_true_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && cond_ok && stk_depth != '0) |=>
            (!in_service && (stk_depth == $past(stk_depth) - 1'b1)));

    assert_false_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !cond_ok) |=> ($stable(in_service) && $stable(stk_depth)));

    assert_false_ret_noload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !cond_ok) |-> !pc_load);

    assert_reserved_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_cond[2:1] == 2'b11) |-> !pc_load);

endmodule

// File: tb/irq_gate_ret_bench.sv
module irq_gate_ret_bench;

    localparam int N   = 8;
    localparam int PW  = 16;
    localparam int DEP = 8;
    localparam logic [PW-1:0] VEC = 16'h0040;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  mod_set, mod_clr, mask_wdata;
    logic          mask_we, insv_we, insv_wdata, ret_valid;
    logic [2:0]    ret_cond;
    logic          flag_c, flag_z, flag_s, fetch_boundary, sw_push, sw_pop;
    logic [PW-1:0] cur_pc, sw_push_data;
    logic          pc_load, in_service, irq_req, stk_err;
    logic [PW-1:0] pc_load_addr, stk_top;
    logic [N-1:0]  irq_id, irq_mask;
    logic [3:0]    stk_depth;

    always #10 clk = ~clk;

    irq_gate_ret u_irq_gate_ret (
        .clk(clk), .rst_n(rst_n), .mod_set(mod_set), .mod_clr(mod_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .insv_we(insv_we),
        .insv_wdata(insv_wdata), .ret_valid(ret_valid), .ret_cond(ret_cond),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
        .fetch_boundary(fetch_boundary), .cur_pc(cur_pc), .sw_push(sw_push),
        .sw_pop(sw_pop), .sw_push_data(sw_push_data), .pc_load(pc_load),
        .pc_load_addr(pc_load_addr), .irq_id(irq_id), .irq_mask(irq_mask),
        .in_service(in_service), .irq_req(irq_req), .stk_top(stk_top),
        .stk_depth(stk_depth), .stk_err(stk_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [N-1:0]  m_id, m_mask;
    logic          m_ins, m_err;
    logic [PW-1:0] m_stk [DEP];
    int            m_sp;

    function automatic logic ref_cond(input logic [2:0] code, input logic c,
                                      input logic z, input logic s);
        case (code)
            3'd0: return 1'b1;
            3'd1: return c;
            3'd2: return !c;
            3'd3: return z;
            3'd4: return !z;
            3'd5: return s;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [PW-1:0] ref_top();
        return (m_sp == 0) ? '0 : m_stk[m_sp-1];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        mod_set = '0; mod_clr = '0; mask_we = 0; mask_wdata = '0;
        insv_we = 0; insv_wdata = 0; ret_valid = 0; ret_cond = 3'd0;
        flag_c = 0; flag_z = 0; flag_s = 0; fetch_boundary = 0;
        cur_pc = '0; sw_push = 0; sw_pop = 0; sw_push_data = '0;
    endtask

    task automatic m_push(input logic [PW-1:0] d);
        if (m_sp == DEP) m_err = 1'b1;
        else begin m_stk[m_sp] = d; m_sp++; end
    endtask

    task automatic m_pop();
        if (m_sp == 0) m_err = 1'b1;
        else m_sp--;
    endtask

    task automatic check_state(input string tag);
        chk("R1", "irq_id", 32'(irq_id), 32'(m_id));
        chk("R5", "irq_mask", 32'(irq_mask), 32'(m_mask));
        chk(tag, "in_service", 32'(in_service), 32'(m_ins));
        chk("R9", "stk_depth", 32'(stk_depth), 32'(m_sp));
        chk("R9", "stk_err", 32'(stk_err), 32'(m_err));
        chk("R10", "stk_top", 32'(stk_top), 32'(ref_top()));
    endtask

    // Called at a negedge after inputs are driven: check, clock, update, check
    task automatic step();
        logic cnd, req, take, rexec, pl;
        logic [PW-1:0] addr;
        string tag;
        #2;
        cnd   = ref_cond(ret_cond, flag_c, flag_z, flag_s);
        req   = !m_ins && ((m_id & m_mask) != '0);
        take  = req && fetch_boundary && !ret_valid;
        rexec = ret_valid && cnd && (m_sp != 0);
        pl    = take || rexec;
        addr  = take ? VEC : ref_top();
        chk("R3", "irq_req", 32'(irq_req), 32'(req));
        if (ret_valid && !cnd)      tag = "R8";
        else if (ret_valid)         tag = "R7";
        else                        tag = "R4";
        if (ret_valid && ret_cond > 3'd5) chk("R6", "pc_load reserved", 32'(pc_load), 32'(0));
        chk(tag, "pc_load", 32'(pc_load), 32'(pl));
        if (pl) chk(tag, "pc_load_addr", 32'(pc_load_addr), 32'(addr));
        @(posedge clk);
        if (take)                  m_push(cur_pc);
        else if (ret_valid && cnd) m_pop();
        else if (!ret_valid) begin
            if (sw_push)     m_push(sw_push_data);
            else if (sw_pop) m_pop();
        end
        if (take)                        m_ins = 1'b1;
        else if (rexec)                  m_ins = 1'b0;
        else if (!ret_valid && insv_we)  m_ins = insv_wdata;
        if (mask_we) m_mask = mask_wdata;
        m_id = (m_id & ~mod_clr) | mod_set;
        @(negedge clk);
        check_state(tag == "R4" ? "R5" : tag);
        idle();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        m_id = '0; m_mask = '0; m_ins = 0; m_err = 0; m_sp = 0;
        for (int i = 0; i < DEP; i++) m_stk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11", "irq_id reset", 32'(irq_id), 32'(0));
        chk("R11", "irq_mask reset", 32'(irq_mask), 32'(0));
        chk("R11", "in_service reset", 32'(in_service), 32'(0));
        chk("R11", "stk_depth reset", 32'(stk_depth), 32'(0));
        chk("R11", "stk_err reset", 32'(stk_err), 32'(0));

        // R1/R3: flag sets under a zero mask, no request
        mod_set = 8'h04; step();
        chk("R1", "masked id set", 32'(irq_id[2]), 32'(1));
        fetch_boundary = 1; step();
        chk("R3", "masked no req", 32'(irq_req), 32'(0));
        // R2: set and clear together, set wins
        mod_set = 8'h04; mod_clr = 8'h04; step();
        chk("R2", "set wins", 32'(irq_id[2]), 32'(1));
        // R3/R4: unmask, then vector at boundary
        mask_we = 1; mask_wdata = 8'h04; step();
        chk("R3", "req after unmask", 32'(irq_req), 32'(1));
        fetch_boundary = 1; cur_pc = 16'h1234; step();
        chk("R4", "vector entered", 32'(in_service), 32'(1));
        chk("R4", "pc pushed", 32'(stk_top), 32'h1234);
        // R5: blocked while in service
        mod_set = 8'h01; mask_we = 1; mask_wdata = 8'hFF; step();
        chk("R5", "blocked", 32'(irq_req), 32'(0));
        // R6/R8: reserved code and false NC
        ret_valid = 1; ret_cond = 3'd6; step();
        ret_valid = 1; ret_cond = 3'd2; flag_c = 1; step();
        chk("R8", "false ret keeps ins", 32'(in_service), 32'(1));
        // R10: software save of mask under the return address
        sw_push = 1; sw_push_data = 16'h00FF; step();
        chk("R10", "sw top", 32'(stk_top), 32'h00FF);
        sw_pop = 1; step();
        // R7: true return on Z
        ret_valid = 1; ret_cond = 3'd3; flag_z = 1; step();
        chk("R7", "ret clears ins", 32'(in_service), 32'(0));
        // R9: true return on empty stack, then overflow
        mod_clr = 8'hFF; mask_we = 1; mask_wdata = 8'h00; step();
        ret_valid = 1; ret_cond = 3'd0; step();
        chk("R9", "underflow err", 32'(stk_err), 32'(1));
        for (int i = 0; i < DEP + 1; i++) begin
            sw_push = 1; sw_push_data = 16'(16'hA000 + i); step();
        end
        chk("R9", "depth at full", 32'(stk_depth), 32'(DEP));
        for (int i = 0; i < DEP; i++) begin
            sw_pop = 1; step();
        end

        // random phase
        for (int k = 0; k < 4000; k++) begin
            mod_set        = N'($urandom & $urandom & $urandom);
            mod_clr        = N'($urandom & $urandom);
            mask_we        = ($urandom % 8) == 0;
            mask_wdata     = N'($urandom);
            insv_we        = ($urandom % 12) == 0;
            insv_wdata     = ($urandom % 4) == 0;
            ret_valid      = ($urandom % 6) == 0;
            ret_cond       = 3'($urandom);
            flag_c         = 1'($urandom);
            flag_z         = 1'($urandom);
            flag_s         = 1'($urandom);
            fetch_boundary = 1'($urandom);
            cur_pc         = PW'($urandom);
            sw_push        = ($urandom % 8) == 0;
            sw_pop         = ($urandom % 7) == 0;
            sw_push_data   = PW'($urandom);
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule